// File: doc/BRIEF.md
# Half-Warp Memory Transaction Coalescer

This block takes one memory request from a group of sixteen threads and turns it into the shortest possible list of aligned memory transactions. A request carries an active-thread mask, one byte address per thread, and one element size shared by all threads. Any active thread may point anywhere. Threads may touch the same element, and they may be in any order relative to the elements they touch.

The block works through the request one transaction at a time. The lowest-numbered active thread that has not yet been served selects an aligned 128-byte segment. Every unserved active thread whose address falls in that segment joins the same transaction. The transaction is then narrowed to an aligned 64-byte half or an aligned 32-byte quarter when all the bytes it uses fit in one. Transactions leave over a valid/ready handshake. A one-cycle done pulse closes each request, and the block accepts the next request only after that pulse.

Top module: `halfwarp_coalescer`

## Requirements
- R1: During and right after a synchronous active-high reset, req_ready_o is 1, and txn_valid_o and done_o are 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. From the next cycle until the cycle after done_o, req_ready_o is 0, and any request presented in that time is ignored.
- R3: A request with an all-zero active mask issues no transaction, and done_o is 1 in the cycle after acceptance.
- R4: The number of transactions equals the number of distinct aligned 128-byte segments touched by the active threads. They are issued in order of the lowest-numbered unserved active thread.
- R5: Each txn_mask_o holds exactly the unserved active threads whose address lies in the same aligned 128-byte segment as the selecting thread. It is never zero, and the masks of one request are disjoint and together equal the active mask.
- R6: txn_size_o is coded 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes. It is 0 if every byte used by the member threads lies in one aligned 32-byte quarter, otherwise 1 if they lie in one aligned 64-byte half, otherwise 2.
- R7: txn_base_o is aligned to the transaction size and is the start of the quarter, half or segment that contains the used bytes.
- R8: req_esz_i is coded 0 = 4 bytes, 1 = 8 bytes, 2 or 3 = 16 bytes. A thread uses the bytes from its address to its address plus the element size minus 1. Addresses are naturally aligned to the element size.
- R9: While txn_valid_o is 1 and txn_ready_i is 0, txn_base_o, txn_size_o and txn_mask_o hold their values. The next transaction appears only after a handshake.
- R10: done_o is a one-cycle pulse in the cycle after the handshake of the last transaction of a request.
- R11: The addresses of inactive threads have no effect on any transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, can take a request |
| req_mask_i | input | 16 | Active thread mask |
| req_addr_i | input | 512 | Byte address per thread, thread i in bits [32*i+31:32*i] |
| req_esz_i | input | 2 | Element size code |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Transaction taken |
| txn_base_o | output | 32 | Aligned transaction base address |
| txn_size_o | output | 2 | Transaction size code |
| txn_mask_o | output | 16 | Threads served by this transaction |
| done_o | output | 1 | Request finished pulse |

## Verification
The bench first runs directed cases:
- An aligned contiguous 4-byte block must give one 64-byte transaction.
- The same block shifted so it straddles a 128-byte boundary must split into two 32-byte transactions.
- A request where all threads share one address must shrink to a single 32-byte transaction.
- Sixteen 16-byte elements must give two full 128-byte transactions.
- An empty mask must give only a done pulse.

Random requests then mix permuted contiguous blocks, strided blocks, and addresses scattered over a few segments, with random masks and random garbage in inactive lanes. These cases separate segment grouping from size narrowing, base selection, and inactive-lane masking. Random back-pressure on txn_ready_i and junk requests sent while the block is busy test the hold, ordering and acceptance rules.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    localparam int NTHR   = 16;
    localparam int AW     = 32;
    localparam int SEG_LG = 7;   // log2 of the largest transaction in bytes

    typedef enum logic [1:0] {
        SZ32  = 2'd0,
        SZ64  = 2'd1,
        SZ128 = 2'd2
    } txn_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } st_e;

    function automatic logic [SEG_LG:0] elem_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd4;
            2'd1:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction
endpackage

// File: rtl/hwc_group.sv
module hwc_group
    import hwc_pkg::*;
#(
    parameter int N  = NTHR,
    parameter int SW = AW - SEG_LG
) (
    input  logic [N-1:0]    pend_i,
    input  logic [N*SW-1:0] seg_flat_i,
    output logic [N-1:0]    grp_o,
    output logic [SW-1:0]   lead_seg_o
);
    logic [SW-1:0] seg_a [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_unpack
            assign seg_a[i] = seg_flat_i[i*SW +: SW];
        end
    endgenerate

    // lowest pending thread picks the segment
    always_comb begin
        lead_seg_o = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (pend_i[i]) lead_seg_o = seg_a[i];
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_match
            assign grp_o[i] = pend_i[i] && (seg_a[i] == lead_seg_o);
        end
    endgenerate
endmodule

// File: rtl/hwc_span.sv
module hwc_span
    import hwc_pkg::*;
#(
    parameter int N  = NTHR,
    parameter int SW = AW - SEG_LG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_en_i,
    input  logic [N-1:0]       grp_i,
    input  logic [N*SEG_LG-1:0] off_flat_i,
    input  logic [1:0]         esz_i,
    input  logic [SW-1:0]      seg_i,
    output logic [SW+SEG_LG-1:0] base_o,
    output txn_sz_e            size_o
);
    localparam logic [SEG_LG-1:0] OFF_MAX = '1;

    logic [SEG_LG-1:0] off_a [N];
    logic [SEG_LG-1:0] lo, hi;
    logic [SEG_LG:0]   last;
    logic [SEG_LG:0]   nbytes;

    generate
        for (genvar i = 0; i < N; i++) begin : g_unpack
            assign off_a[i] = off_flat_i[i*SEG_LG +: SEG_LG];
        end
    endgenerate

    assign nbytes = elem_bytes(esz_i);

    // byte span used inside the selected segment
    always_comb begin
        lo   = OFF_MAX;
        hi   = '0;
        last = '0;
        for (int i = 0; i < N; i++) begin
            if (grp_i[i]) begin
                last = {1'b0, off_a[i]} + nbytes - 1'b1;
                if (off_a[i] < lo) lo = off_a[i];
                if (last[SEG_LG]) hi = OFF_MAX;
                else if (last[SEG_LG-1:0] > hi) hi = last[SEG_LG-1:0];
            end
        end
    end

    always_comb begin
        if (lo[SEG_LG-1:SEG_LG-2] == hi[SEG_LG-1:SEG_LG-2]) begin
            size_o = SZ32;
            base_o = {seg_i, lo[SEG_LG-1:SEG_LG-2], {(SEG_LG-2){1'b0}}};
        end else if (lo[SEG_LG-1] == hi[SEG_LG-1]) begin
            size_o = SZ64;
            base_o = {seg_i, lo[SEG_LG-1], {(SEG_LG-1){1'b0}}};
        end else begin
            size_o = SZ128;
            base_o = {seg_i, {SEG_LG{1'b0}}};
        end
    end

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        chk_en_i |-> (size_o != 2'd3)) else $error("illegal size"); // R6

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        chk_en_i |-> (base_o[SEG_LG-3:0] == '0)
                 && (size_o == SZ32 || base_o[SEG_LG-2] == 1'b0)
                 && (size_o != SZ128 || base_o[SEG_LG-1] == 1'b0))
        else $error("base misaligned"); // R7
endmodule

// File: rtl/halfwarp_coalescer.sv
module halfwarp_coalescer
    import hwc_pkg::*;
#(
    parameter int N = NTHR,
    parameter int W = AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid_i,
    output logic           req_ready_o,
    input  logic [N-1:0]   req_mask_i,
    input  logic [N*W-1:0] req_addr_i,
    input  logic [1:0]     req_esz_i,
    output logic           txn_valid_o,
    input  logic           txn_ready_i,
    output logic [W-1:0]   txn_base_o,
    output logic [1:0]     txn_size_o,
    output logic [N-1:0]   txn_mask_o,
    output logic           done_o
);
    localparam int SW = W - SEG_LG;

    st_e                 state;
    logic [N-1:0]        pend;
    logic [N*W-1:0]      addr_q;
    logic [1:0]          esz_q;
    logic [N*SW-1:0]     seg_flat;
    logic [N*SEG_LG-1:0] off_flat;
    logic [N-1:0]        grp;
    logic [SW-1:0]       lead_seg;
    logic [N-1:0]        pend_nx;
    txn_sz_e             size_w;

    generate
        for (genvar i = 0; i < N; i++) begin : g_split
            assign seg_flat[i*SW +: SW]         = addr_q[i*W+SEG_LG +: SW];
            assign off_flat[i*SEG_LG +: SEG_LG] = addr_q[i*W +: SEG_LG];
        end
    endgenerate

    hwc_group #(.N(N), .SW(SW)) u_group (
        .pend_i     (pend),
        .seg_flat_i (seg_flat),
        .grp_o      (grp),
        .lead_seg_o (lead_seg)
    );

    hwc_span #(.N(N), .SW(SW)) u_span (
        .clk        (clk),
        .rst        (rst),
        .chk_en_i   (txn_valid_o),
        .grp_i      (grp),
        .off_flat_i (off_flat),
        .esz_i      (esz_q),
        .seg_i      (lead_seg),
        .base_o     (txn_base_o),
        .size_o     (size_w)
    );

    assign pend_nx     = pend & ~grp;
    assign req_ready_o = (state == ST_IDLE);
    assign txn_valid_o = (state == ST_ISSUE);
    assign done_o      = (state == ST_DONE);
    assign txn_mask_o  = grp;
    assign txn_size_o  = size_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pend   <= '0;
            addr_q <= '0;
            esz_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid_i) begin
                    pend   <= req_mask_i;
                    addr_q <= req_addr_i;
                    esz_q  <= req_esz_i;
                    state  <= (req_mask_i == '0) ? ST_DONE : ST_ISSUE;
                end
                ST_ISSUE: if (txn_ready_i) begin
                    pend <= pend_nx;
                    if (pend_nx == '0) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_TXN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (txn_valid_o && !txn_ready_i) |=> (txn_valid_o && $stable(txn_base_o)
            && $stable(txn_size_o) && $stable(txn_mask_o)))
        else $error("txn changed under backpressure"); // R9

    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        txn_valid_o |-> (txn_mask_o != '0)) else $error("empty txn"); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && req_ready_o)) else $error("done not a pulse"); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o) else $error("ready after accept"); // R2
endmodule

// File: tb/halfwarp_coalescer_tb.sv
module halfwarp_coalescer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int W = 32;
    localparam int WATCHDOG = 150000;

    logic           clk = 1'b0;
    logic           rst;
    logic           req_valid_i;
    logic           req_ready_o;
    logic [N-1:0]   req_mask_i;
    logic [N*W-1:0] req_addr_i;
    logic [1:0]     req_esz_i;
    logic           txn_valid_o;
    logic           txn_ready_i;
    logic [W-1:0]   txn_base_o;
    logic [1:0]     txn_size_o;
    logic [N-1:0]   txn_mask_o;
    logic           done_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [W-1:0] ta [N];
    logic [W-1:0] e_base [N];
    logic [1:0]   e_size [N];
    logic [N-1:0] e_mask [N];
    int           e_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfwarp_coalescer u_dut (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_mask_i(req_mask_i), .req_addr_i(req_addr_i), .req_esz_i(req_esz_i),
        .txn_valid_o(txn_valid_o), .txn_ready_i(txn_ready_i),
        .txn_base_o(txn_base_o), .txn_size_o(txn_size_o), .txn_mask_o(txn_mask_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ebytes(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : 16;
    endfunction

    // reference: greedy per 128-byte segment, then narrow
    task automatic ref_model(input logic [N-1:0] mask, input logic [1:0] esz);
        logic [N-1:0] pend;
        logic [W-1:0] seg;
        int lo, hi, b;
        pend = mask;
        e_n  = 0;
        b    = ebytes(esz);
        while (pend != '0) begin
            int lead;
            lead = 0;
            for (int i = N-1; i >= 0; i--) if (pend[i]) lead = i;
            seg = ta[lead] >> 7;
            e_mask[e_n] = '0;
            lo = 127; hi = 0;
            for (int i = 0; i < N; i++) begin
                if (pend[i] && (ta[i] >> 7) == seg) begin
                    e_mask[e_n][i] = 1'b1;
                    if (int'(ta[i][6:0]) < lo) lo = int'(ta[i][6:0]);
                    if (int'(ta[i][6:0]) + b - 1 > hi) hi = int'(ta[i][6:0]) + b - 1;
                end
            end
            if (hi > 127) hi = 127;
            if (lo / 32 == hi / 32) begin
                e_size[e_n] = 2'd0; e_base[e_n] = (seg << 7) + W'((lo / 32) * 32);
            end else if (lo / 64 == hi / 64) begin
                e_size[e_n] = 2'd1; e_base[e_n] = (seg << 7) + W'((lo / 64) * 64);
            end else begin
                e_size[e_n] = 2'd2; e_base[e_n] = seg << 7;
            end
            pend = pend & ~e_mask[e_n];
            e_n++;
        end
    endtask

    task automatic run_req(input logic [N-1:0] mask, input logic [1:0] esz);
        int  k;
        bit  exp_done;
        bit  hs;
        ref_model(mask, esz);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1;
        req_mask_i  = mask;
        req_esz_i   = esz;
        for (int i = 0; i < N; i++) req_addr_i[i*W +: W] = ta[i];
        @(negedge clk);
        req_valid_i = 1'b0;
        exp_done = (mask == '0);   // R3: done right after an empty request
        k = 0;
        forever begin
            chk(done_o == exp_done, exp_done ? "R10 done pulse" : "R10 early done",
                64'(done_o), 64'(exp_done));
            if (done_o) break;
            chk(!req_ready_o, "R2 ready while busy", 64'(req_ready_o), 64'd0);
            // junk requests while busy must be ignored (R2)
            req_valid_i = $urandom_range(0, 1) == 1;
            req_mask_i  = N'($urandom);
            for (int i = 0; i < N; i++) req_addr_i[i*W +: W] = $urandom;
            txn_ready_i = $urandom_range(0, 3) != 0;
            if (txn_valid_o) begin
                if (k < e_n) begin
                    chk(txn_mask_o == e_mask[k], "R5 mask", 64'(txn_mask_o), 64'(e_mask[k]));
                    chk(txn_size_o == e_size[k], "R6 size", 64'(txn_size_o), 64'(e_size[k]));
                    chk(txn_base_o == e_base[k], "R7 base", 64'(txn_base_o), 64'(e_base[k]));
                end else begin
                    chk(1'b0, "R4 extra transaction", 64'(k), 64'(e_n));
                end
            end
            hs = txn_valid_o && txn_ready_i;
            exp_done = hs && (k + 1 == e_n);
            if (hs) k++;
            @(negedge clk);
        end
        req_valid_i = 1'b0;
        txn_ready_i = 1'b0;
        chk(k == e_n, "R4 transaction count", 64'(k), 64'(e_n));
    endtask

    task automatic fill_rand(output logic [N-1:0] mask, output logic [1:0] esz);
        logic [W-1:0] region;
        int b, mode, k0, stride, rot;
        esz    = 2'($urandom_range(0, 3));
        b      = ebytes(esz);
        region = {$urandom, 9'b0};
        mode   = $urandom_range(0, 3);
        k0     = $urandom_range(0, 15);
        stride = $urandom_range(1, 5);
        rot    = $urandom_range(0, 15);
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (i * 7 + rot) % 16;
            case (mode)
                0: ta[i] = region + W'((k0 + idx) * b);
                1: ta[i] = region + W'((k0 + idx * stride) * b);
                2: ta[i] = region + W'($urandom_range(0, 63) * b);
                default: ta[i] = region + W'(k0 * b);
            endcase
        end
        case ($urandom_range(0, 3))
            0: mask = '1;
            1: mask = N'($urandom) & N'($urandom);
            default: mask = N'($urandom);
        endcase
        // inactive lanes get garbage (R11)
        for (int i = 0; i < N; i++) if (!mask[i]) ta[i] = $urandom;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [N-1:0] m;
        logic [1:0]   e;
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid_i = 1'b0; txn_ready_i = 1'b0;
        req_mask_i = '0; req_addr_i = '0; req_esz_i = '0;
        repeat (3) @(negedge clk);
        chk(req_ready_o && !txn_valid_o && !done_o, "R1 in reset",
            {req_ready_o, txn_valid_o, done_o}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready_o && !txn_valid_o && !done_o, "R1 after reset",
            {req_ready_o, txn_valid_o, done_o}, 3'b100);

        // R3 empty request, lanes full of garbage
        for (int i = 0; i < N; i++) ta[i] = $urandom;
        run_req('0, 2'd0);

        // R4/R6 aligned contiguous 4-byte block -> one 64-byte txn
        for (int i = 0; i < N; i++) ta[i] = 32'h1000 + W'(i * 4);
        run_req('1, 2'd0);
        chk(e_n == 1 && e_size[0] == 2'd1, "R6 aligned block", 64'(e_n), 64'd1);

        // R4 block straddling a 128-byte boundary -> two 32-byte txns
        for (int i = 0; i < N; i++) ta[i] = 32'h2060 + W'(i * 4);
        run_req('1, 2'd0);
        chk(e_n == 2 && e_size[0] == 2'd0 && e_size[1] == 2'd0, "R4 straddle",
            64'(e_n), 64'd2);

        // R6 broadcast address -> single 32-byte txn
        for (int i = 0; i < N; i++) ta[i] = 32'h3048;
        run_req('1, 2'd1);
        chk(e_n == 1 && e_size[0] == 2'd0 && e_base[0] == 32'h3040, "R6 broadcast",
            64'(e_base[0]), 64'h3040);

        // R8 16-byte elements, permuted -> two 128-byte txns
        for (int i = 0; i < N; i++) ta[i] = 32'h4000 + W'(((i * 5) % 16) * 16);
        run_req('1, 2'd2);
        chk(e_n == 2 && e_size[0] == 2'd2, "R8 16B elements", 64'(e_n), 64'd2);

        // R11 single active lane among garbage
        for (int i = 0; i < N; i++) ta[i] = $urandom;
        ta[9] = 32'h50E8;
        run_req(16'h0200, 2'd1);

        for (int t = 0; t < 200; t++) begin
            fill_rand(m, e);
            run_req(m, e);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule